// File: doc/BRIEF.md
# Sender Retransmission and Persist Timer

This unit supplies the timing and loss-recovery decisions for a reduced TCP sender that only ever acts as a client and moves data in one direction. A single down-counter is shared by three jobs. It paces SYN retries while the connection is being opened. It runs the retransmission timeout while bytes are in flight. It runs the zero-window persist timer when nothing is owed but the peer leaves no room to send. The retransmission timeout doubles on every expiry up to a ceiling. It returns to its base value whenever an acknowledgement moves the oldest unacknowledged byte forward.

Alongside the timer, the unit keeps the unacknowledged and next-to-send pointers in units of 8-byte words, because the payload path stores 64-bit words. It counts duplicate acknowledgements and requests an immediate resend of the oldest segment on the third one. It also derives a send-enable from the advertised window, which holds back small sends. The surrounding sender reports each transmitted segment and each received acknowledgement, and acts on the retransmit, probe and SYN-retry pulses.

Top module: `tcp_tx_timer`

## Requirements
- R1: After reset, `send_en`, `retx_req`, `probe_req` and `syn_retry` are all low.
- R2: `sender_state` is encoded 0 closed, 1 connecting, 2 established (3 is treated as closed). While connecting, `syn_retry` pulses for one cycle CONN_TICKS+1 cycles after the state is first presented, then every CONN_TICKS cycles.
- R3: In the established state, once unacknowledged data appears after an idle period, `retx_req` pulses BASE_RTO+2 cycles after the first `seg_sent` cycle, and `retx_seq` then equals the oldest unacknowledged byte number.
- R4: Each retransmission timeout doubles the next timeout (BASE_RTO·2, ·4, …) until it saturates at BASE_RTO·2^MAX_SHIFT.
- R5: An acknowledgement that advances the unacknowledged pointer restores the base timeout and restarts the timer, so the next timeout follows BASE_RTO+1 cycles after the acknowledgement cycle.
- R6: While data is outstanding, every `seg_sent` reloads the timer with the current (possibly backed-off) timeout, so `retx_req` follows that timeout plus one cycle later.
- R7: When every sent byte is acknowledged and `send_en` is high, the timer stops and no retransmit or probe pulse is produced.
- R8: The third word-aligned acknowledgement that repeats the current unacknowledged number while data is outstanding raises `retx_req` on the next cycle with `retx_seq` equal to that number. Further repeats give no more pulses until the pointer advances. An acknowledgement whose low three bits are non-zero is never counted as a repeat.
- R9: `send_en` is high only when established and the usable window (advertised window minus outstanding bytes, floored at zero) is at least MIN_WIN. Windows wider than 16 bits are used in full.
- R10: When established, with nothing outstanding and `send_en` low, `probe_req` pulses PERSIST_TICKS+1 cycles after that condition starts, then every PERSIST_TICKS cycles.
- R11: Sequence numbers are held in 8-byte words. An acknowledgement number is rounded down to its word, and `retx_seq` always has its low three bits at zero.
- R12: In the closed state both pointers load from `isn`, the window reads zero, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sender_state | input | 2 | 0 closed, 1 connecting, 2 established |
| isn | input | SEQ_W | First data byte number, word aligned, loaded while not established |
| seg_sent | input | 1 | One-cycle strobe: a segment was transmitted |
| seg_end | input | SEQ_W | Byte number just past the transmitted segment (word aligned) |
| ack_valid | input | 1 | One-cycle strobe: an acknowledgement arrived |
| ack_num | input | SEQ_W | Acknowledgement number carried by it |
| ack_win | input | WIN_W | Advertised window in bytes, already scaled |
| send_en | output | 1 | New data may be sent |
| retx_req | output | 1 | One-cycle request to resend from `retx_seq` |
| retx_seq | output | SEQ_W | Oldest unacknowledged byte number |
| probe_req | output | 1 | One-cycle request to send a window probe |
| syn_retry | output | 1 | One-cycle request to resend the SYN |

## Verification
The hardest state to reach is the saturated back-off followed by a partial acknowledgement. The counter must first run through several full, growing timeouts with the same segment still unacknowledged, and then be cut short by an acknowledgement that lands on an unaligned byte. The bench reaches it by small timer constants, by letting the first timeout chain run to its ceiling and measuring every interval, and then by acknowledging a byte inside a word. The same interval measurements then show the return to the base value and the back-off level carried into a later segment reload.

// File: rtl/segtmr_pkg.sv
package segtmr_pkg;

    typedef enum logic [1:0] {
        ST_CLOSED  = 2'd0,
        ST_CONNECT = 2'd1,
        ST_OPEN    = 2'd2,
        ST_SPARE   = 2'd3
    } snd_state_e;

    typedef enum logic [1:0] {
        TM_OFF,
        TM_CONN,
        TM_RETX,
        TM_PERSIST
    } tmr_mode_e;

    typedef struct packed {
        logic syn;
        logic probe;
        logic rto;
    } tmr_fire_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return $clog2(v + 1);
    endfunction

endpackage

// File: rtl/segtmr_track.sv
module segtmr_track
    import segtmr_pkg::*;
#(
    parameter int unsigned SEQ_W    = 32,
    parameter int unsigned WIN_W    = 24,
    parameter int unsigned DUP_ACKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  snd_state_e        state,
    input  logic [SEQ_W-1:0]  isn,
    input  logic              seg_sent,
    input  logic [SEQ_W-1:0]  seg_end,
    input  logic              ack_valid,
    input  logic [SEQ_W-1:0]  ack_num,
    input  logic [WIN_W-1:0]  ack_win,
    output logic [SEQ_W-4:0]  una_w,
    output logic [SEQ_W-4:0]  nxt_w,
    output logic [WIN_W-1:0]  win_q,
    output logic              adv,
    output logic              fast_q
);
    localparam int unsigned QW = SEQ_W - 3;
    localparam int unsigned DW = bits_for(DUP_ACKS);

    logic          is_open;
    logic [QW-1:0] ack_w, seg_w, d_ack, d_out, d_seg;
    logic          dup, seg_ahead;
    logic [DW-1:0] dup_cnt;

    assign is_open   = (state == ST_OPEN);
    assign ack_w     = ack_num[SEQ_W-1:3];
    assign seg_w     = seg_end[SEQ_W-1:3];
    assign d_ack     = ack_w - una_w;
    assign d_out     = nxt_w - una_w;
    assign d_seg     = seg_w - nxt_w;
    assign adv       = is_open && ack_valid && (d_ack != '0) && (d_ack <= d_out);
    assign dup       = is_open && ack_valid && (d_ack == '0) && (d_out != '0)
                       && (ack_num[2:0] == 3'd0);
    assign seg_ahead = is_open && seg_sent && (d_seg != '0) && !d_seg[QW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            una_w   <= '0;
            nxt_w   <= '0;
            win_q   <= '0;
            dup_cnt <= '0;
            fast_q  <= 1'b0;
        end else if (!is_open) begin
            una_w   <= isn[SEQ_W-1:3];
            nxt_w   <= isn[SEQ_W-1:3];
            win_q   <= '0;
            dup_cnt <= '0;
            fast_q  <= 1'b0;
        end else begin
            fast_q <= 1'b0;
            if (adv)       una_w <= ack_w;
            if (seg_ahead) nxt_w <= seg_w;
            if (ack_valid) win_q <= ack_win;
            if (adv) begin
                dup_cnt <= '0;
            end else if (dup && (dup_cnt < DW'(DUP_ACKS))) begin
                dup_cnt <= dup_cnt + 1'b1;
                if (dup_cnt == DW'(DUP_ACKS - 1)) fast_q <= 1'b1;
            end
        end
    end

    AST_FAST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fast_q |=> !fast_q);  // R8

    AST_ISN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        !is_open |-> (isn[2:0] == 3'd0));  // R11

endmodule

// File: rtl/segtmr_backoff.sv
module segtmr_backoff #(
    parameter int unsigned BASE_RTO  = 64,
    parameter int unsigned MAX_SHIFT = 4,
    parameter int unsigned TW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          rto_fire,
    output logic [TW-1:0] retx_load
);
    localparam int unsigned SW = $clog2(MAX_SHIFT + 1);

    logic [SW-1:0] sh, next_sh;

    always_comb begin
        if (clear)
            next_sh = '0;
        else if (rto_fire && (sh < SW'(MAX_SHIFT)))
            next_sh = sh + 1'b1;
        else
            next_sh = sh;
    end

    assign retx_load = TW'(BASE_RTO) << next_sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= next_sh;
    end

    AST_SHIFT_CAP: assert property (@(posedge clk) disable iff (rst)
        sh <= SW'(MAX_SHIFT));  // R4

    AST_CLEAR_BASE: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sh == '0));  // R5

endmodule

// File: rtl/segtmr_clock.sv
module segtmr_clock
    import segtmr_pkg::*;
#(
    parameter int unsigned CONN_TICKS    = 200,
    parameter int unsigned PERSIST_TICKS = 150,
    parameter int unsigned TW            = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_mode_e     mode,
    input  logic          kick,
    input  logic [TW-1:0] retx_load,
    output logic          rto_fire,
    output tmr_fire_t     fire_q
);
    tmr_mode_e     mode_q;
    logic [TW-1:0] cnt, load_val;
    logic          mode_chg, reload_now, expire;

    always_comb begin
        case (mode)
            TM_CONN:    load_val = TW'(CONN_TICKS);
            TM_RETX:    load_val = retx_load;
            TM_PERSIST: load_val = TW'(PERSIST_TICKS);
            default:    load_val = '0;
        endcase
    end

    assign mode_chg   = (mode != mode_q);
    assign reload_now = !mode_chg && (mode == TM_RETX) && kick;
    assign expire     = !mode_chg && (mode != TM_OFF) && !reload_now && (cnt == TW'(1));
    assign rto_fire   = expire && (mode == TM_RETX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mode_q <= TM_OFF;
            fire_q <= '0;
        end else begin
            mode_q       <= mode;
            fire_q.syn   <= expire && (mode == TM_CONN);
            fire_q.probe <= expire && (mode == TM_PERSIST);
            fire_q.rto   <= rto_fire;
            if (mode_chg || reload_now || expire)
                cnt <= load_val;
            else if (mode == TM_OFF)
                cnt <= '0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire_q));  // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_OFF) |=> (cnt == '0));  // R7

endmodule

// File: rtl/tcp_tx_timer.sv
module tcp_tx_timer
    import segtmr_pkg::*;
#(
    parameter int unsigned SEQ_W         = 32,
    parameter int unsigned WIN_W         = 24,
    parameter int unsigned BASE_RTO      = 64,
    parameter int unsigned MAX_SHIFT     = 4,
    parameter int unsigned CONN_TICKS    = 200,
    parameter int unsigned PERSIST_TICKS = 150,
    parameter int unsigned MIN_WIN       = 512,
    parameter int unsigned DUP_ACKS      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sender_state,
    input  logic [SEQ_W-1:0] isn,
    input  logic             seg_sent,
    input  logic [SEQ_W-1:0] seg_end,
    input  logic             ack_valid,
    input  logic [SEQ_W-1:0] ack_num,
    input  logic [WIN_W-1:0] ack_win,
    output logic             send_en,
    output logic             retx_req,
    output logic [SEQ_W-1:0] retx_seq,
    output logic             probe_req,
    output logic             syn_retry
);
    localparam int unsigned QW = SEQ_W - 3;
    localparam int unsigned TW = bits_for(max3(BASE_RTO << MAX_SHIFT, CONN_TICKS, PERSIST_TICKS));

    snd_state_e    st;
    logic          is_open;
    logic [QW-1:0] una_w, nxt_w, d_out;
    logic [WIN_W-1:0] win_q;
    logic          adv, fast_q, owed;
    logic [SEQ_W-1:0] out_bytes, win_ext, usable;
    tmr_mode_e     mode;
    logic          kick, rto_fire;
    logic [TW-1:0] retx_load;
    tmr_fire_t     fire;

    assign st      = snd_state_e'(sender_state);
    assign is_open = (st == ST_OPEN);

    segtmr_track #(.SEQ_W(SEQ_W), .WIN_W(WIN_W), .DUP_ACKS(DUP_ACKS)) u_track (
        .clk(clk), .rst(rst), .state(st), .isn(isn),
        .seg_sent(seg_sent), .seg_end(seg_end),
        .ack_valid(ack_valid), .ack_num(ack_num), .ack_win(ack_win),
        .una_w(una_w), .nxt_w(nxt_w), .win_q(win_q), .adv(adv), .fast_q(fast_q)
    );

    assign d_out     = nxt_w - una_w;
    assign owed      = (d_out != '0);
    assign out_bytes = {d_out, 3'b000};
    assign win_ext   = SEQ_W'(win_q);
    assign usable    = (win_ext > out_bytes) ? (win_ext - out_bytes) : '0;
    assign send_en   = is_open && (usable >= SEQ_W'(MIN_WIN));

    always_comb begin
        if (st == ST_CONNECT)      mode = TM_CONN;
        else if (!is_open)         mode = TM_OFF;
        else if (owed)             mode = TM_RETX;
        else if (!send_en)         mode = TM_PERSIST;
        else                       mode = TM_OFF;
    end

    assign kick = (is_open && seg_sent) || adv;

    segtmr_backoff #(.BASE_RTO(BASE_RTO), .MAX_SHIFT(MAX_SHIFT), .TW(TW)) u_backoff (
        .clk(clk), .rst(rst), .clear(adv || !is_open),
        .rto_fire(rto_fire), .retx_load(retx_load)
    );

    segtmr_clock #(.CONN_TICKS(CONN_TICKS), .PERSIST_TICKS(PERSIST_TICKS), .TW(TW)) u_clock (
        .clk(clk), .rst(rst), .mode(mode), .kick(kick),
        .retx_load(retx_load), .rto_fire(rto_fire), .fire_q(fire)
    );

    assign retx_req  = fast_q || fire.rto;
    assign retx_seq  = {una_w, 3'b000};
    assign probe_req = fire.probe;
    assign syn_retry = fire.syn;

    AST_SEND_OPEN: assert property (@(posedge clk) disable iff (rst)
        send_en |-> (sender_state == 2'd2));  // R9

    AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (is_open && seg_sent) |-> (seg_end[2:0] == 3'd0));  // R11

endmodule

// File: tb/tcp_tx_timer_bench.sv
`timescale 1ns/1ps
module tcp_tx_timer_bench;
    localparam int B = 8;
    localparam int MS = 2;
    localparam int CT = 12;
    localparam int PT = 10;
    localparam int MW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sender_state = 2'd0;
    logic [31:0] isn = 32'h0;
    logic        seg_sent = 1'b0;
    logic [31:0] seg_end = 32'h0;
    logic        ack_valid = 1'b0;
    logic [31:0] ack_num = 32'h0;
    logic [23:0] ack_win = 24'h0;
    logic        send_en, retx_req, probe_req, syn_retry;
    logic [31:0] retx_seq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    tcp_tx_timer #(.SEQ_W(32), .WIN_W(24), .BASE_RTO(B), .MAX_SHIFT(MS),
                   .CONN_TICKS(CT), .PERSIST_TICKS(PT), .MIN_WIN(MW), .DUP_ACKS(3))
    u_tcp_tx_timer (
        .clk(clk), .rst(rst), .sender_state(sender_state), .isn(isn),
        .seg_sent(seg_sent), .seg_end(seg_end), .ack_valid(ack_valid),
        .ack_num(ack_num), .ack_win(ack_win), .send_en(send_en),
        .retx_req(retx_req), .retx_seq(retx_seq), .probe_req(probe_req),
        .syn_retry(syn_retry)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic evt(input int sel);
        case (sel)
            0: return syn_retry;
            1: return probe_req;
            default: return retx_req;
        endcase
    endfunction

    task automatic wait_evt(input int sel, input int limit, output int n);
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (evt(sel)) return;
            if (n >= limit) begin
                n = -1;
                return;
            end
        end
    endtask

    task automatic quiet(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (retx_req || probe_req || syn_retry) hits++;
        end
    endtask

    task automatic do_ack(input logic [31:0] num, input logic [23:0] w);
        ack_num = num;
        ack_win = w;
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_seg(input logic [31:0] e);
        seg_end = e;
        seg_sent = 1'b1;
        @(negedge clk);
        seg_sent = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int h;
        int iv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 send_en", send_en, 0);
        check("R1 pulses", {retx_req, probe_req, syn_retry}, 0);

        // R2 connecting: SYN retry pacing
        sender_state = 2'd1;
        wait_evt(0, 100, n);
        check("R2 first syn_retry", n, CT + 1);
        for (int k = 0; k < 2; k++) begin
            wait_evt(0, 100, n);
            check("R2 syn_retry period", n, CT);
        end
        check("R2 send_en low", send_en, 0);

        // R12 closed: pointers load, nothing fires
        sender_state = 2'd0;
        isn = 32'h1000;
        quiet(40, h);
        check("R12 no pulses closed", h, 0);
        check("R12 send_en closed", send_en, 0);

        // R10 persist: established, zero window
        sender_state = 2'd2;
        wait_evt(1, 100, n);
        check("R10 first probe", n, PT + 1);
        wait_evt(1, 100, n);
        check("R10 probe period", n, PT);
        check("R10 send_en low", send_en, 0);

        // R9 window opens, persist stops (R7)
        do_ack(32'h1000, 24'd4096);
        check("R9 send_en open", send_en, 1);
        quiet(30, h);
        check("R7 idle quiet", h, 0);

        // R3 first retransmit timeout
        do_seg(32'h1040);
        wait_evt(2, 200, n);
        check("R3 first timeout", n + 1, B + 2);
        check("R3 retx_seq", retx_seq, 32'h1000);

        // R4 back-off sweep: doubling then saturation
        iv = B;
        for (int k = 0; k < 4; k++) begin
            iv = (k < MS) ? iv * 2 : iv;
            wait_evt(2, 400, n);
            check("R4 backoff interval", n, iv);
        end

        // R5 + R11 partial, unaligned advance
        do_ack(32'h1015, 24'd4096);
        wait_evt(2, 200, n);
        check("R5 base after advance", n + 1, B + 1);
        check("R11 retx_seq rounded", retx_seq, 32'h1010);

        // R6 segment reload uses current level (one doubling)
        do_seg(32'h1050);
        wait_evt(2, 200, n);
        check("R6 reload interval", n + 1, 2 * B + 1);

        // R8 fast retransmit
        do_ack(32'h1020, 24'd4096);
        check("R8 advance no pulse", retx_req, 0);
        for (int k = 0; k < 3; k++) begin
            do_ack(32'h1023, 24'd4096);
            check("R8 unaligned not dup", retx_req, 0);
        end
        do_ack(32'h1020, 24'd4096);
        check("R8 dup1", retx_req, 0);
        do_ack(32'h1020, 24'd4096);
        check("R8 dup2", retx_req, 0);
        do_ack(32'h1020, 24'd4096);
        check("R8 dup3 fires", retx_req, 1);
        check("R8 retx_seq", retx_seq, 32'h1020);
        do_ack(32'h1020, 24'd4096);
        check("R8 dup4 silent", retx_req, 0);

        // R9 window boundaries, outstanding 48 bytes
        do_ack(32'h1020, 24'(48 + MW - 1));
        check("R9 usable below min", send_en, 0);
        do_ack(32'h1020, 24'(48 + MW));
        check("R9 usable at min", send_en, 1);
        do_ack(32'h1020, 24'd65576);
        check("R9 wide window", send_en, 1);
        do_ack(32'h1020, 24'd40);
        check("R9 window below outstanding", send_en, 0);

        // R7 all acknowledged: timer stops
        do_ack(32'h1050, 24'd4096);
        check("R7 send_en", send_en, 1);
        quiet(80, h);
        check("R7 no pulses", h, 0);

        // R12 back to closed
        sender_state = 2'd0;
        quiet(30, h);
        check("R12 closed quiet", h, 0);
        check("R12 send_en", send_en, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule